// File: doc/BRIEF.md
# Floating-Point Register NaN-Box Adapter

This adapter sits between a 64-bit floating-point register file and execution units that work in half, single and double precision. On the write side it places a narrower result into a full register word by filling every bit above the value with ones. A half value therefore ends up boxed inside a single, which is itself boxed inside a double. On the read side it checks that the stored word carries the boxing the instruction's precision needs. If it does, the narrow operand is handed on, zero-extended. If it does not, a canonical quiet NaN takes its place and an indication is raised. No trap is ever taken. The adapter also reports the narrowest width whose boxing pattern the stored word satisfies.

Loads, stores and integer moves set a raw-move flag. In a raw move the 64-bit word passes through bit for bit on both paths, so a boxed narrow value survives a trip through memory or an integer register unchanged. A double-precision read needs no special handling, because a boxed narrow value already reads as a NaN at double width. Checking, unboxing and width detection are combinational. A parameter can add one output register stage.

Top module: `fp_box_adapter`

## Requirements
- R1: With raw-move low and write format single (2'b01), the write word is bits 63:32 all ones over the low 32 bits of the write value.
- R2: With raw-move low and write format half (2'b00), the write word is bits 63:16 all ones over the low 16 bits of the write value.
- R3: With raw-move low and write format double (2'b10) or the unused code 2'b11, the write word equals the write value.
- R4: With raw-move high, the write word equals the write value and the read operand equals the register word, whatever the formats. The invalid-box flag stays low.
- R5: A single-format read of a word whose bits 63:32 are all ones returns bits 31:0, zero-extended, with the invalid-box flag low.
- R6: A single-format read of a word whose bits 63:32 are not all ones returns 32'h7FC00000, zero-extended, with the invalid-box flag high.
- R7: A half-format read of a word whose bits 63:16 are all ones returns bits 15:0, zero-extended, with the invalid-box flag low.
- R8: A half-format read of a word whose bits 63:16 are not all ones returns 16'h7E00, zero-extended, with the invalid-box flag high. This includes a word that is boxed only as a single.
- R9: A double-format read (2'b10 or 2'b11) returns the whole word with the invalid-box flag low, even when the word holds a boxed narrow value.
- R10: The width tag is 2'b00 when bits 63:16 are all ones, otherwise 2'b01 when bits 63:32 are all ones, otherwise 2'b10. This holds regardless of the raw-move flag or the requested format.
- R11: A word equal to a valid box except that bit 63 is 0 is not a valid box. Narrow reads of it give the canonical NaN, and its width tag is 2'b10.
- R12: With OUT_REG = 1, every output is zero while reset is held. After reset, each output reflects the inputs of the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, used only by the optional output stage |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_word | input | 64 | Word read from the register file |
| rd_fmt | input | 2 | Requested read format: 00 half, 01 single, 10/11 double |
| wr_val | input | 64 | Result value to be written |
| wr_fmt | input | 2 | Format of the write value, same encoding |
| raw_move | input | 1 | High for a load, store or integer move: bits pass unchanged |
| wr_word | output | 64 | Boxed word for the register file |
| rd_operand | output | 64 | Unboxed operand, zero-extended, or substituted NaN |
| rd_bad_box | output | 1 | High when a narrow read found invalid boxing |
| rd_width | output | 2 | Narrowest width whose boxing the read word satisfies |

## Verification
The bench builds the adapter with its default OUT_REG = 1. With that setting the reset value of every output can be seen at the ports. Each result also has to appear exactly one edge after its inputs, so a wrong latency or a stale stage is caught. The combinational variant uses the same datapath modules without the stage, and the bound checker covers it through its delayed-input switch.

// File: rtl/fpbox_pkg.sv
// Package: shared widths, format codes and canonical NaN constants for the
// NaN-box adapter. Assumes a 64-bit register word with 32- and 16-bit
// narrow formats nested inside it.
package fpbox_pkg;
    localparam int WORD_W   = 64;
    localparam int SINGLE_W = 32;
    localparam int HALF_W   = 16;
    localparam int FMT_W    = 2;

    typedef enum logic [FMT_W-1:0] {
        FMT_HALF   = 2'b00,
        FMT_SINGLE = 2'b01,
        FMT_DOUBLE = 2'b10,
        FMT_SPARE  = 2'b11
    } fp_fmt_e;

    localparam logic [SINGLE_W-1:0] QNAN_SINGLE = 32'h7FC0_0000;
    localparam logic [HALF_W-1:0]   QNAN_HALF   = 16'h7E00;

    // Box a value of width nbits into a full word (upper bits forced to one).
    function automatic logic [WORD_W-1:0] box_to_word(input logic [WORD_W-1:0] val,
                                                      input int nbits);
        logic [WORD_W-1:0] mask;
        mask = {WORD_W{1'b1}} << nbits;
        return mask | (val & ~mask);
    endfunction
endpackage

// File: rtl/fpbox_writer.sv
// Module: write-side boxing. Fills every bit above a narrow result with ones,
// or passes the value untouched for double format or a raw move.
// Assumes: format code 2'b11 is treated as double.
module fpbox_writer
    import fpbox_pkg::*;
(
    input  logic [WORD_W-1:0] wr_val,
    input  fp_fmt_e           wr_fmt,
    input  logic              raw_move,
    output logic [WORD_W-1:0] wr_word
);
    // Select boxed or verbatim write word.
    always_comb begin
        if (raw_move) begin
            wr_word = wr_val;
        end else begin
            unique case (wr_fmt)
                FMT_HALF:   wr_word = box_to_word(wr_val, HALF_W);
                FMT_SINGLE: wr_word = box_to_word(wr_val, SINGLE_W);
                default:    wr_word = wr_val;
            endcase
        end
    end
endmodule

// File: rtl/fpbox_width_detect.sv
// Module: inspects a register word and flags which narrow boxings it
// satisfies; reports the narrowest satisfied width as a format code.
// Assumes: half boxing implies single boxing (nested pattern).
module fpbox_width_detect
    import fpbox_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output logic              half_ok,
    output logic              single_ok,
    output fp_fmt_e           width
);
    localparam int N_CHK = 2;
    localparam int CHK_W [N_CHK] = '{HALF_W, SINGLE_W};

    logic [N_CHK-1:0] ok_vec;

    // One upper-bits-all-ones detector per narrow width.
    for (genvar g = 0; g < N_CHK; g++) begin : g_chk
        assign ok_vec[g] = &word[WORD_W-1:CHK_W[g]];
    end

    assign half_ok   = ok_vec[0];
    assign single_ok = ok_vec[1];

    // Narrowest satisfied width wins.
    always_comb begin
        if (half_ok)        width = FMT_HALF;
        else if (single_ok) width = FMT_SINGLE;
        else                width = FMT_DOUBLE;
    end
endmodule

// File: rtl/fpbox_reader.sv
// Module: read-side unboxing. For a narrow request, passes the zero-extended
// low bits when the box is valid, otherwise substitutes a canonical quiet NaN
// and raises the bad-box flag. Double requests and raw moves pass the word.
// Assumes: validity flags come from fpbox_width_detect on the same word.
module fpbox_reader
    import fpbox_pkg::*;
(
    input  logic [WORD_W-1:0] rd_word,
    input  fp_fmt_e           rd_fmt,
    input  logic              raw_move,
    input  logic              half_ok,
    input  logic              single_ok,
    output logic [WORD_W-1:0] operand,
    output logic              bad_box
);
    logic [WORD_W-1:0] half_val;
    logic [WORD_W-1:0] single_val;

    assign half_val   = {{(WORD_W-HALF_W){1'b0}},   half_ok   ? rd_word[HALF_W-1:0]   : QNAN_HALF};
    assign single_val = {{(WORD_W-SINGLE_W){1'b0}}, single_ok ? rd_word[SINGLE_W-1:0] : QNAN_SINGLE};

    // Choose operand and flag from requested format.
    always_comb begin
        operand = rd_word;
        bad_box = 1'b0;
        if (!raw_move) begin
            unique case (rd_fmt)
                FMT_HALF: begin
                    operand = half_val;
                    bad_box = !half_ok;
                end
                FMT_SINGLE: begin
                    operand = single_val;
                    bad_box = !single_ok;
                end
                default: begin
                    operand = rd_word;
                    bad_box = 1'b0;
                end
            endcase
        end
    end
endmodule

// File: rtl/fp_box_adapter.sv
// Module: top of the NaN-box adapter. Combines write boxing, read unboxing
// and stored-width detection; OUT_REG = 1 adds one output register stage
// with synchronous active-low reset, OUT_REG = 0 leaves all paths combinational.
module fp_box_adapter
    import fpbox_pkg::*;
#(
    parameter bit OUT_REG = 1'b1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [WORD_W-1:0]   rd_word,
    input  logic [FMT_W-1:0]    rd_fmt,
    input  logic [WORD_W-1:0]   wr_val,
    input  logic [FMT_W-1:0]    wr_fmt,
    input  logic                raw_move,
    output logic [WORD_W-1:0]   wr_word,
    output logic [WORD_W-1:0]   rd_operand,
    output logic                rd_bad_box,
    output logic [FMT_W-1:0]    rd_width
);
    logic [WORD_W-1:0] wr_word_c;
    logic [WORD_W-1:0] operand_c;
    logic              bad_c;
    logic              half_ok;
    logic              single_ok;
    fp_fmt_e           width_c;

    fpbox_writer u_writer (
        .wr_val   (wr_val),
        .wr_fmt   (fp_fmt_e'(wr_fmt)),
        .raw_move (raw_move),
        .wr_word  (wr_word_c)
    );

    fpbox_width_detect u_detect (
        .word      (rd_word),
        .half_ok   (half_ok),
        .single_ok (single_ok),
        .width     (width_c)
    );

    fpbox_reader u_reader (
        .rd_word   (rd_word),
        .rd_fmt    (fp_fmt_e'(rd_fmt)),
        .raw_move  (raw_move),
        .half_ok   (half_ok),
        .single_ok (single_ok),
        .operand   (operand_c),
        .bad_box   (bad_c)
    );

    if (OUT_REG) begin : g_reg
        // Output stage: capture all results, clear on reset.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                wr_word    <= '0;
                rd_operand <= '0;
                rd_bad_box <= 1'b0;
                rd_width   <= '0;
            end else begin
                wr_word    <= wr_word_c;
                rd_operand <= operand_c;
                rd_bad_box <= bad_c;
                rd_width   <= width_c;
            end
        end
    end else begin : g_comb
        assign wr_word    = wr_word_c;
        assign rd_operand = operand_c;
        assign rd_bad_box = bad_c;
        assign rd_width   = width_c;
    end
endmodule

// File: rtl/fpbox_checker.sv
// Module: assertion checker bound to fp_box_adapter. Rebuilds the inputs
// that the current outputs belong to (delayed by one edge when OUT_REG = 1)
// and checks port relations against them.
module fpbox_checker
    import fpbox_pkg::*;
#(
    parameter bit OUT_REG = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [WORD_W-1:0] rd_word,
    input logic [FMT_W-1:0]  rd_fmt,
    input logic [WORD_W-1:0] wr_val,
    input logic [FMT_W-1:0]  wr_fmt,
    input logic              raw_move,
    input logic [WORD_W-1:0] wr_word,
    input logic [WORD_W-1:0] rd_operand,
    input logic              rd_bad_box,
    input logic [FMT_W-1:0]  rd_width
);
    logic [WORD_W-1:0] s_word;
    logic [FMT_W-1:0]  s_fmt;
    logic [WORD_W-1:0] s_wval;
    logic [FMT_W-1:0]  s_wfmt;
    logic              s_raw;
    logic              s_valid;

    if (OUT_REG) begin : g_dly
        // Hold the inputs the registered outputs were computed from.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                s_word  <= '0;
                s_fmt   <= '0;
                s_wval  <= '0;
                s_wfmt  <= '0;
                s_raw   <= 1'b0;
                s_valid <= 1'b0;
            end else begin
                s_word  <= rd_word;
                s_fmt   <= rd_fmt;
                s_wval  <= wr_val;
                s_wfmt  <= wr_fmt;
                s_raw   <= raw_move;
                s_valid <= 1'b1;
            end
        end
    end else begin : g_now
        assign s_word  = rd_word;
        assign s_fmt   = rd_fmt;
        assign s_wval  = wr_val;
        assign s_wfmt  = wr_fmt;
        assign s_raw   = raw_move;
        assign s_valid = 1'b1;
    end

    a_r1_single_box: assert property (@(posedge clk) disable iff (!rst_n)
        (s_valid && !s_raw && s_wfmt == FMT_SINGLE) |->
        (wr_word[63:32] == 32'hFFFF_FFFF && wr_word[31:0] == s_wval[31:0]));

    a_r4_raw_read: assert property (@(posedge clk) disable iff (!rst_n)
        (s_valid && s_raw) |-> (rd_operand == s_word && !rd_bad_box));

    a_r6_single_nan: assert property (@(posedge clk) disable iff (!rst_n)
        (s_valid && rd_bad_box && s_fmt == FMT_SINGLE) |->
        (rd_operand == {32'h0, QNAN_SINGLE}));

    a_r9_double_clean: assert property (@(posedge clk) disable iff (!rst_n)
        (s_valid && s_fmt[1]) |-> !rd_bad_box);

    a_r10_half_tag: assert property (@(posedge clk) disable iff (!rst_n)
        (s_valid && rd_width == FMT_HALF) |-> (s_word[63:16] == 48'hFFFF_FFFF_FFFF));
endmodule

bind fp_box_adapter fpbox_checker #(.OUT_REG(OUT_REG)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_word    (rd_word),
    .rd_fmt     (rd_fmt),
    .wr_val     (wr_val),
    .wr_fmt     (wr_fmt),
    .raw_move   (raw_move),
    .wr_word    (wr_word),
    .rd_operand (rd_operand),
    .rd_bad_box (rd_bad_box),
    .rd_width   (rd_width)
);

// File: tb/sim_fp_box_adapter.sv
`timescale 1ns/1ps
module sim_fp_box_adapter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] rd_word = '0;
    logic [1:0]  rd_fmt = '0;
    logic [63:0] wr_val = '0;
    logic [1:0]  wr_fmt = '0;
    logic        raw_move = 1'b0;
    logic [63:0] wr_word;
    logic [63:0] rd_operand;
    logic        rd_bad_box;
    logic [1:0]  rd_width;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    fp_box_adapter u0 (
        .clk(clk), .rst_n(rst_n), .rd_word(rd_word), .rd_fmt(rd_fmt),
        .wr_val(wr_val), .wr_fmt(wr_fmt), .raw_move(raw_move),
        .wr_word(wr_word), .rd_operand(rd_operand),
        .rd_bad_box(rd_bad_box), .rd_width(rd_width)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Count of consecutive ones from bit 63 downward.
    function automatic int lead_ones(input logic [63:0] w);
        int n = 0;
        for (int i = 63; i >= 0; i--) begin
            if (w[i]) n++;
            else break;
        end
        return n;
    endfunction

    // Reference model: drive one vector, compute expected results, compare one edge later.
    task automatic run(input logic [63:0] w, input logic [1:0] f,
                       input logic [63:0] v, input logic [1:0] wf,
                       input logic r, input string req);
        logic [63:0] e_wr, e_op;
        logic        e_bad;
        logic [1:0]  e_wid;
        int          lo;
        @(negedge clk);
        rd_word = w; rd_fmt = f; wr_val = v; wr_fmt = wf; raw_move = r;
        lo = lead_ones(w);
        if (r)             e_wr = v;
        else if (wf == 0)  e_wr = {48'hFFFF_FFFF_FFFF, v[15:0]};
        else if (wf == 1)  e_wr = {32'hFFFF_FFFF, v[31:0]};
        else               e_wr = v;
        e_op = w; e_bad = 0;
        if (!r && f == 0) begin
            e_bad = (lo < 48);
            e_op  = e_bad ? 64'h7E00 : {48'h0, w[15:0]};
        end else if (!r && f == 1) begin
            e_bad = (lo < 32);
            e_op  = e_bad ? 64'h7FC0_0000 : {32'h0, w[31:0]};
        end
        e_wid = (lo >= 48) ? 2'd0 : (lo >= 32) ? 2'd1 : 2'd2;
        @(posedge clk);
        #2;
        chk(wr_word == e_wr,       req, "wr_word",    wr_word,    e_wr);
        chk(rd_operand == e_op,    req, "rd_operand", rd_operand, e_op);
        chk(rd_bad_box == e_bad,   req, "rd_bad_box", {63'h0, rd_bad_box}, {63'h0, e_bad});
        chk(rd_width == e_wid,     "R10", "rd_width", {62'h0, rd_width},   {62'h0, e_wid});
    endtask

    initial begin
        // R12: reset clears the output stage
        rd_word = 64'hFFFF_FFFF_FFFF_1234; rd_fmt = 2'd0;
        wr_val  = 64'h1111_2222_3333_4444; wr_fmt = 2'd1;
        repeat (3) @(posedge clk);
        #2;
        chk(wr_word == 0,    "R12", "reset wr_word",    wr_word,    0);
        chk(rd_operand == 0, "R12", "reset rd_operand", rd_operand, 0);
        chk(rd_bad_box == 0, "R12", "reset rd_bad_box", {63'h0, rd_bad_box}, 0);
        chk(rd_width == 0,   "R12", "reset rd_width",   {62'h0, rd_width},   0);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 single write boxing; R5 valid single read
        run(64'hFFFF_FFFF_4049_0FDB, 2'd1, 64'h1234_5678_3F80_0000, 2'd1, 0, "R1");
        run(64'hFFFF_FFFF_C000_0000, 2'd1, 64'h0000_0000_0000_0001, 2'd1, 0, "R5");
        // R2 half write boxing; R7 valid half read
        run(64'hFFFF_FFFF_FFFF_3C00, 2'd0, 64'hDEAD_BEEF_0000_ABCD, 2'd0, 0, "R2");
        run(64'hFFFF_FFFF_FFFF_FFFF, 2'd0, 64'hFFFF_0000_FFFF_0000, 2'd0, 0, "R7");
        // R3 double and spare code write pass-through
        run(64'h4009_21FB_5444_2D18, 2'd2, 64'h4009_21FB_5444_2D18, 2'd2, 0, "R3");
        run(64'h0000_0000_0000_0000, 2'd3, 64'h8000_0000_0000_0001, 2'd3, 0, "R3");
        // R6 badly boxed single
        run(64'h0000_0000_4049_0FDB, 2'd1, 64'h0, 2'd2, 0, "R6");
        run(64'hFFFF_FFFE_3F80_0000, 2'd1, 64'h0, 2'd2, 0, "R6");
        // R8 badly boxed half, including single-only box
        run(64'hFFFF_FFFF_0000_3C00, 2'd0, 64'h0, 2'd2, 0, "R8");
        run(64'h0000_0000_0000_3C00, 2'd0, 64'h0, 2'd2, 0, "R8");
        // R9 double reads of boxed narrow values
        run(64'hFFFF_FFFF_3F80_0000, 2'd2, 64'h0, 2'd2, 0, "R9");
        run(64'hFFFF_FFFF_FFFF_3C00, 2'd3, 64'h0, 2'd2, 0, "R9");
        // R11 positive-sign pattern is not a box
        run(64'h7FFF_FFFF_3F80_0000, 2'd1, 64'h0, 2'd2, 0, "R11");
        run(64'h7FFF_FFFF_FFFF_3C00, 2'd0, 64'h0, 2'd2, 0, "R11");
        // R4 raw moves keep bits exactly on both paths
        run(64'h0000_0000_4049_0FDB, 2'd1, 64'h0123_4567_89AB_CDEF, 2'd0, 1, "R4");
        run(64'hFFFF_FFFF_3F80_0000, 2'd0, 64'hFFFF_FFFF_3F80_0000, 2'd1, 1, "R4");
        // R12 back-to-back vectors: each result belongs to its own edge
        run(64'hFFFF_FFFF_FFFF_0001, 2'd0, 64'h5, 2'd0, 0, "R12");
        run(64'h0000_0000_0000_0002, 2'd0, 64'h6, 2'd1, 0, "R12");
        run(64'hFFFF_FFFF_0000_0003, 2'd1, 64'h7, 2'd2, 0, "R12");

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule